// File: doc/BRIEF.md
# Successive-Approximation ADC Sequencer

This block is the digital half of a successive-approximation analog-to-digital converter. It drives a sample/hold stage, feeds trial codes to an external DAC, and reads back a comparator. The comparator's output is 1 when the held analog input is at or above the DAC output. A single-cycle `go` starts a conversion. The block puts the sample/hold into hold mode and waits a programmable acquisition time. It then resolves one bit per trial, from MSB to LSB.

Each trial sets the bit under test in the DAC code and waits a programmable number of settling cycles. That wait also covers the two-flop synchronizer on the comparator input. The block then keeps the bit or clears it. Every conversion therefore takes the same number of cycles. At the end, `done` pulses for one cycle with the result on `data`. `data` keeps that value until the next conversion finishes.

Top module: `sar_adc_ctrl`

## Requirements
- R1: After reset `busy`, `hold` and `done` are 0, and `dac_code` and `data` are all zeros.
- R2: A `go` sampled while idle makes `busy` and `hold` both 1 from the following cycle.
- R3: `hold` stays asserted for HOLD_WAIT cycles with `dac_code` at zero. The first trial code is then MSB set and all other bits 0.
- R4: Each trial sets the bit under test to 1 and leaves the lower bits 0. The bit is kept when the synchronized comparator reads 1 (input at or above the DAC) and cleared when it reads 0. Bits go MSB first. An input exactly equal to a code keeps that code's bit.
- R5: Each trial lasts SETTLE cycles, with SETTLE of at least 3. The comparator passes through two flops before it is used, so later changes of the live analog input do not affect the result.
- R6: `done` is a one-cycle pulse. It rises exactly HOLD_WAIT + N*SETTLE cycles after the cycle in which `go` was sampled, and `data` carries the result during that cycle.
- R7: `data` does not change between `done` pulses.
- R8: `hold` is 1 throughout the trials and 0 in the cycle `done` is high.
- R9: A `go` that arrives while `busy` is 1 has no effect: there is no extra `done` and the latency of the current conversion does not change.
- R10: With N=3, an input between 2 and 3 LSB gives 3'b010.
- R11: An input below 1 LSB gives all zeros. An input at or above full scale gives all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| go | input | 1 | Start pulse, acted on only while idle |
| cmp_in | input | 1 | Asynchronous comparator output, 1 when held input is at or above the DAC |
| hold | output | 1 | Sample/hold control, 1 = hold |
| dac_code | output | N | Trial code to the DAC |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle result strobe |
| data | output | N | Last conversion result |

## Verification
The assertions assume that `go` is synchronous to `clk`. They also assume that the comparator settles well within one cycle of a `dac_code` change, and that the held value does not move while `hold` is 1. The bench meets these conditions as follows. Its comparator is a combinational compare between `dac_code` and a value latched on the rising edge of `hold`. It changes the live input only on falling clock edges, and only after the hold has captured it. `go` is driven for exactly one cycle, apart from a deliberate second pulse in the middle of a conversion.

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl #(
  parameter int N         = 8,
  parameter int SETTLE    = 4,
  parameter int HOLD_WAIT = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic         cmp_in,
  output logic         hold,
  output logic [N-1:0] dac_code,
  output logic         busy,
  output logic         done,
  output logic [N-1:0] data
);
  localparam int CMAX = (SETTLE > HOLD_WAIT) ? SETTLE : HOLD_WAIT;
  localparam int CW   = $clog2(CMAX + 1);
  localparam int BW   = $clog2(N);
  localparam logic [N-1:0] MSB = {1'b1, {(N-1){1'b0}}};

  typedef enum logic [1:0] {S_IDLE, S_ACQ, S_TRIAL} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [BW-1:0] bidx;
  logic          sy1, sy2;
  logic [N-1:0]  bit_mask, keep_code;

  assign busy      = (st != S_IDLE);
  assign bit_mask  = {{(N-1){1'b0}}, 1'b1} << bidx;
  assign keep_code = sy2 ? dac_code : (dac_code & ~bit_mask);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sy1 <= 1'b0;
      sy2 <= 1'b0;
    end else begin
      sy1 <= cmp_in;
      sy2 <= sy1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      bidx     <= '0;
      hold     <= 1'b0;
      dac_code <= '0;
      done     <= 1'b0;
      data     <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE:
          if (go) begin
            st   <= S_ACQ;
            hold <= 1'b1;
            cnt  <= '0;
          end
        S_ACQ:
          if (cnt == CW'(HOLD_WAIT - 1)) begin
            st       <= S_TRIAL;
            cnt      <= '0;
            bidx     <= BW'(N - 1);
            dac_code <= MSB;
          end else
            cnt <= cnt + 1'b1;
        S_TRIAL:
          if (cnt == CW'(SETTLE - 1)) begin
            cnt <= '0;
            if (bidx == '0) begin
              data     <= keep_code;
              done     <= 1'b1;
              hold     <= 1'b0;
              dac_code <= '0;
              st       <= S_IDLE;
            end else begin
              dac_code <= keep_code | (bit_mask >> 1);
              bidx     <= bidx - 1'b1;
            end
          end else
            cnt <= cnt + 1'b1;
        default: st <= S_IDLE;
      endcase
    end

  p_hold_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> hold);

  p_first_trial_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_TRIAL && $past(st) == S_ACQ) |-> dac_code == MSB);

  p_low_bits_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_TRIAL) |-> (dac_code & (bit_mask - 1'b1)) == '0);

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_data_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(data));

  p_hold_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !hold && !busy);

  p_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_TRIAL && go) |=> st != S_ACQ);
endmodule

// File: tb/sim_sar_adc_ctrl.sv
module sim_sar_adc_ctrl;
  localparam int N = 8, SETTLE = 4, HW = 2, LAT = HW + N * SETTLE;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, go, go3;
  logic hold, busy, done, hold3, busy3, done3;
  logic [N-1:0] dac, data;
  logic [2:0] dac3, data3;
  logic cmp, cmp3;
  int vin_q = 0, held_q = 0, vin3_q = 0, held3_q = 0;
  int errors = 0, checks = 0, done_cnt = 0, e_mon = 0, cyc = 0;
  int exp_q[$];

  assign cmp  = held_q  >= 4 * int'(dac);
  assign cmp3 = held3_q >= 4 * int'(dac3);
  always @(posedge hold)  held_q  = vin_q;
  always @(posedge hold3) held3_q = vin3_q;

  sar_adc_ctrl #(.N(N), .SETTLE(SETTLE), .HOLD_WAIT(HW)) u0 (
    .clk(clk), .rst_n(rst_n), .go(go), .cmp_in(cmp), .hold(hold),
    .dac_code(dac), .busy(busy), .done(done), .data(data));

  sar_adc_ctrl #(.N(3), .SETTLE(3), .HOLD_WAIT(1)) u1 (
    .clk(clk), .rst_n(rst_n), .go(go3), .cmp_in(cmp3), .hold(hold3),
    .dac_code(dac3), .busy(busy3), .done(done3), .data(data3));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk)
    if (rst_n && done) begin
      done_cnt++;
      if (exp_q.size() == 0) chk(1'b0, "R9 unexpected done", int'(data), -1);
      else begin
        e_mon = exp_q.pop_front();
        chk(int'(data) == e_mon, "R4 R11 result", int'(data), e_mon);
      end
    end

  task automatic convert(input int q, input bit extra_go);
    int e, n, dc;
    e = q / 4;
    if (e > 2**N - 1) e = 2**N - 1;
    exp_q.push_back(e);
    vin_q = q;
    @(negedge clk) go = 1'b1;
    @(posedge clk) n = 1;
    @(negedge clk) go = 1'b0;
    chk(busy && hold, "R2 busy/hold after go", {busy, hold}, 3);
    while (!done && n < LAT + 20) begin
      if (n == HW) chk(dac == '0, "R3 code zero while acquiring", int'(dac), 0);
      if (n == HW + 1) begin
        chk(int'(dac) == 2**(N-1), "R3 first trial code", int'(dac), 2**(N-1));
        chk(hold, "R8 hold during trials", hold, 1);
      end
      if (n == 3) vin_q = 4 * (2**N - 1) - q;
      if (extra_go && n == 10) go = 1'b1;
      if (extra_go && n == 11) go = 1'b0;
      @(posedge clk) n++;
      @(negedge clk);
    end
    chk(n == LAT + 1, "R5 R6 latency", n - 1, LAT);
    chk(!hold, "R8 hold released at done", hold, 0);
    @(negedge clk);
    chk(!done, "R6 done single cycle", done, 0);
    repeat (4) @(negedge clk);
    chk(int'(data) == e, "R7 data held", int'(data), e);
    if (extra_go) begin
      dc = done_cnt;
      repeat (LAT + 5) @(negedge clk);
      chk(done_cnt == dc && !busy, "R9 go while busy ignored", done_cnt, dc);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; go = 1'b0; go3 = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy && !hold && !done && dac == '0 && data == '0, "R1 reset state",
        {busy, hold, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && data == '0, "R1 idle after reset", int'(data), 0);

    convert(4 * 170 + 2, 1'b0);
    convert(4 * 85 + 1, 1'b0);
    convert(4 * 128, 1'b0);        // R4 equal input keeps bit
    convert(4 * 127 + 3, 1'b0);
    convert(1, 1'b0);              // R11 zero
    convert(4 * 255 + 3, 1'b0);    // R11 full scale
    convert(4 * 300, 1'b0);        // R11 above full scale
    convert(4 * 37 + 2, 1'b1);     // R9

    vin3_q = 10;
    @(negedge clk) go3 = 1'b1;
    @(negedge clk) go3 = 1'b0;
    begin
      int k;
      k = 0;
      while (!done3 && k < 100) begin
        @(negedge clk) k++;
      end
    end
    chk(data3 == 3'b010, "R10 three-bit example", int'(data3), 2);

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R6 all results seen", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule